// File: doc/BRIEF.md
# Multiplexed Bus Memory Glue

This block joins a microcontroller whose external bus shares one byte of lines between the low address and the data with a set of byte-wide external memories. The controller sets the upper address byte on its own port and, while the bus clock E is low, the lower address byte on the shared lines, marked by an address strobe. The block holds that lower byte in a register, so the full 16-bit address stays valid for the whole access. Once E rises, the shared lines carry data.

The rebuilt address feeds a 1-of-8 region decoder with three enable inputs. One of those enables is the inverted E clock, so no chip select can become active during the address half of the cycle. Three regions are served:
- a 2 KiB device at 0x5000,
- a 2 KiB device at 0x6800,
- a 512-byte device in the 2 KiB window at 0x5800, which is only partially decoded, so each of its cells answers at four addresses.

The write and output strobes are also limited to the high half of E. The read path onto the shared lines is enabled only while a read hits a decoded region. It is released as E falls, and in every other cycle the read path carries a fixed idle byte. Every access completes within one E cycle; there are no wait states.

Top module: `xbus_mem_glue`

## Requirements
- R1: While `as_stb` is high and `e_clk` is low, the byte on `ad_in` is captured at the next rising `clk` edge. At all other times the captured byte holds, even when `ad_in` carries data. After reset the captured byte is 0x00.
- R2: `addr_full` equals `{addr_hi, captured low byte}`.
- R3: While `e_clk` is high, exactly one chip select is active (low):
  - `cs_n[0]` for `addr_full` 0x5000–0x57FF (bits 15:11 = 01010),
  - `cs_n[1]` for 0x5800–0x5FFF (bits 15:11 = 01011),
  - `cs_n[2]` for 0x6800–0x6FFF (bits 15:11 = 01101).
- R4: While `e_clk` is low, all of `cs_n`, `we_n` and `oe_n` are high and `bus_drv_en` is low. An address outside the three regions leaves all of `cs_n` high in either half of the cycle.
- R5: While `cs_n[1]` is low, `mem_addr` is `{2'b00, addr_full[8:0]}`, so bits 10:9 are ignored. Otherwise `mem_addr` is `addr_full[10:0]`. A byte written at 0x5801 is read back at 0x5A01, 0x5C01 and 0x5E01.
- R6: `we_n` is low exactly when `e_clk` is high and `rw_n` is 0 (write). `mem_wdata` follows `ad_in`.
- R7: `oe_n` is low exactly when `e_clk` is high and `rw_n` is 1 (read). `we_n` and `oe_n` are never low together.
- R8: `bus_drv_en` is high exactly when `e_clk` is high, `rw_n` is 1 and a chip select is low. `bus_rd_data` then equals `mem_rdata`; in every other case it is 0xFF.
- R9: A byte written into a region is returned by a later read of the same cell, and a read outside every region returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the address register |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_clk | input | 1 | Bus clock E; high half is the data phase |
| as_stb | input | 1 | Address strobe, high while the low address is valid |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 8 | Upper address byte |
| ad_in | input | 8 | Shared low-address/data lines as seen by the block |
| mem_rdata | input | 8 | Read data from the selected memory |
| addr_full | output | 16 | Rebuilt 16-bit address |
| mem_addr | output | 11 | Address to the memory pins (masked for the mirrored region) |
| mem_wdata | output | 8 | Write data to the memories |
| cs_n | output | 3 | Active-low chip selects, one per region |
| we_n | output | 1 | Active-low write enable |
| oe_n | output | 1 | Active-low output enable |
| bus_drv_en | output | 1 | Enables the driver from memory onto the shared lines |
| bus_rd_data | output | 8 | Byte offered to the shared lines on a read |

## Verification
The hardest case to reach is the aliasing of the 512-byte region. It only shows when a write at one mirror address is read back through another mirror address, with an independent write to a different mirror in between. The stimulus does exactly that in both directions: a write at 0x5801 is read at 0x5A01, 0x5C01 and 0x5E01, and a write at 0x5FFF is read at 0x59FF. Alongside, a swept set of addresses across all three windows and the gaps between them compares every read against a reference store indexed by the masked offset.

The second hard case is a shared-line value changing while the address must hold. The bench therefore puts a data byte different from the address on `ad_in` before E rises and checks that the rebuilt address has not moved.

// File: rtl/xbus_glue_pkg.sv
package xbus_glue_pkg;
    localparam int unsigned REGION_CNT = 3;
    localparam logic [7:0]  IDLE_BYTE  = 8'hFF;

    typedef enum logic [1:0] {
        RG_LOW    = 2'd0,
        RG_MIRROR = 2'd1,
        RG_HIGH   = 2'd2
    } region_e;
endpackage

// File: rtl/xbus_lo_latch.sv
module xbus_lo_latch #(
    parameter int unsigned LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            e_clk,
    input  logic            as_stb,
    input  logic [LO_W-1:0] ad_in,
    output logic [LO_W-1:0] addr_lo
);
    typedef struct packed {
        logic [LO_W-1:0] addr_lo;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (as_stb && !e_clk) begin
            st_d.addr_lo = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_lo = st_q.addr_lo;

    // R1
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_stb && !e_clk) |=> (addr_lo == $past(ad_in)));

    // R1
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_stb && !e_clk) |=> $stable(addr_lo));
endmodule

// File: rtl/xbus_dec1of8.sv
module xbus_dec1of8 #(
    parameter int unsigned SEL_W = 3,
    localparam int unsigned OUT_N = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             en_hi,
    input  logic             en_lo_a,
    input  logic             en_lo_b,
    output logic [OUT_N-1:0] y_n
);
    logic enabled;
    assign enabled = en_hi & ~en_lo_a & ~en_lo_b;

    for (genvar k = 0; k < OUT_N; k++) begin : g_out
        assign y_n[k] = ~(enabled && (sel == SEL_W'(k)));
    end

    // R3
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~y_n));

    // R4
    dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_hi || en_lo_a || en_lo_b) |-> (&y_n));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
    parameter int unsigned REGION_CNT = 3,
    parameter int unsigned DEV_AW     = 11,
    parameter int unsigned MIRROR_AW  = 9,
    parameter int unsigned MIRROR_IDX = 1,
    parameter int unsigned DW         = 8,
    parameter logic [7:0]  IDLE       = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  e_clk,
    input  logic                  rw_n,
    input  logic [REGION_CNT-1:0] sel_n,
    input  logic [DEV_AW-1:0]     dev_addr,
    input  logic [DW-1:0]         mem_rdata,
    output logic [REGION_CNT-1:0] cs_n,
    output logic [DEV_AW-1:0]     mem_addr,
    output logic                  we_n,
    output logic                  oe_n,
    output logic                  bus_drv_en,
    output logic [DW-1:0]         bus_rd_data
);
    localparam int unsigned MASK_W = DEV_AW - MIRROR_AW;

    logic any_sel;

    always_comb begin
        any_sel     = ~(&sel_n);
        cs_n        = sel_n;
        we_n        = ~(e_clk & ~rw_n);
        oe_n        = ~(e_clk & rw_n);
        bus_drv_en  = e_clk & rw_n & any_sel;
        bus_rd_data = bus_drv_en ? mem_rdata : DW'(IDLE);
    end

    if (MASK_W > 0) begin : g_mask
        assign mem_addr = sel_n[MIRROR_IDX] ? dev_addr
                                            : {{MASK_W{1'b0}}, dev_addr[MIRROR_AW-1:0]};
    end else begin : g_nomask
        assign mem_addr = dev_addr;
    end

    // R7
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    // R8
    drv_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv_en |-> (!oe_n && (cs_n != '1)));

    // R5
    mirror_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n[MIRROR_IDX] |-> (mem_addr[DEV_AW-1:MIRROR_AW] == '0));
endmodule

// File: rtl/xbus_mem_glue.sv
module xbus_mem_glue
    import xbus_glue_pkg::*;
#(
    parameter int unsigned HI_W        = 8,
    parameter int unsigned LO_W        = 8,
    parameter int unsigned DW          = 8,
    parameter int unsigned DEV_AW      = 11,
    parameter int unsigned MIRROR_AW   = 9,
    parameter int unsigned SEL_W       = 3,
    parameter logic [2:0]  CODE_LOW    = 3'd2,
    parameter logic [2:0]  CODE_MIRROR = 3'd3,
    parameter logic [2:0]  CODE_HIGH   = 3'd5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  e_clk,
    input  logic                  as_stb,
    input  logic                  rw_n,
    input  logic [HI_W-1:0]       addr_hi,
    input  logic [LO_W-1:0]       ad_in,
    input  logic [DW-1:0]         mem_rdata,
    output logic [HI_W+LO_W-1:0]  addr_full,
    output logic [DEV_AW-1:0]     mem_addr,
    output logic [DW-1:0]         mem_wdata,
    output logic [REGION_CNT-1:0] cs_n,
    output logic                  we_n,
    output logic                  oe_n,
    output logic                  bus_drv_en,
    output logic [DW-1:0]         bus_rd_data
);
    localparam int unsigned ADDR_W = HI_W + LO_W;
    localparam int unsigned OUT_N  = 1 << SEL_W;
    localparam logic [REGION_CNT*SEL_W-1:0] CODES = {CODE_HIGH, CODE_MIRROR, CODE_LOW};

    logic [LO_W-1:0]       addr_lo;
    logic [OUT_N-1:0]      y_n;
    logic [REGION_CNT-1:0] sel_n;

    xbus_lo_latch #(.LO_W(LO_W)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .e_clk   (e_clk),
        .as_stb  (as_stb),
        .ad_in   (ad_in),
        .addr_lo (addr_lo)
    );

    assign addr_full = {addr_hi, addr_lo};
    assign mem_wdata = ad_in;

    // Enables: upper window bit high, top bit low, E high (inverted E on an active-low enable).
    xbus_dec1of8 #(.SEL_W(SEL_W)) i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (addr_full[DEV_AW +: SEL_W]),
        .en_hi   (addr_full[ADDR_W-2]),
        .en_lo_a (addr_full[ADDR_W-1]),
        .en_lo_b (~e_clk),
        .y_n     (y_n)
    );

    for (genvar g = 0; g < REGION_CNT; g++) begin : g_region
        assign sel_n[g] = y_n[CODES[g*SEL_W +: SEL_W]];
    end

    xbus_strobe_gen #(
        .REGION_CNT (REGION_CNT),
        .DEV_AW     (DEV_AW),
        .MIRROR_AW  (MIRROR_AW),
        .MIRROR_IDX (int'(RG_MIRROR)),
        .DW         (DW),
        .IDLE       (IDLE_BYTE)
    ) i_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .e_clk       (e_clk),
        .rw_n        (rw_n),
        .sel_n       (sel_n),
        .dev_addr    (addr_full[DEV_AW-1:0]),
        .mem_rdata   (mem_rdata),
        .cs_n        (cs_n),
        .mem_addr    (mem_addr),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .bus_drv_en  (bus_drv_en),
        .bus_rd_data (bus_rd_data)
    );

    // R4
    low_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !e_clk |-> ((&cs_n) && (&y_n) && we_n && oe_n && !bus_drv_en));

    // R2
    addr_hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_full[ADDR_W-1:LO_W] == addr_hi);
endmodule

// File: tb/test_xbus_mem_glue.sv
module test_xbus_mem_glue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_clk = 1'b0;
    logic        as_stb = 1'b0;
    logic        rw_n = 1'b1;
    logic [7:0]  addr_hi = 8'h00;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  mem_rdata;
    logic [15:0] addr_full;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [2:0]  cs_n;
    logic        we_n, oe_n, bus_drv_en;
    logic [7:0]  bus_rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xbus_mem_glue i_xbus_mem_glue (
        .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .as_stb(as_stb), .rw_n(rw_n),
        .addr_hi(addr_hi), .ad_in(ad_in), .mem_rdata(mem_rdata),
        .addr_full(addr_full), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .bus_drv_en(bus_drv_en),
        .bus_rd_data(bus_rd_data)
    );

    // Behavioural memories, driven only from the design's ports
    logic [7:0] dev0 [2048];
    logic [7:0] dev1 [512];
    logic [7:0] dev2 [2048];
    // Reference store, indexed from the requirement address map
    logic [7:0] ref0 [2048];
    logic [7:0] ref1 [512];
    logic [7:0] ref2 [2048];

    always @(posedge clk) begin
        if (!we_n) begin
            if (!cs_n[0]) dev0[mem_addr] <= mem_wdata;
            if (!cs_n[1] && mem_addr < 11'd512) dev1[mem_addr[8:0]] <= mem_wdata;
            if (!cs_n[2]) dev2[mem_addr] <= mem_wdata;
        end
    end

    always_comb begin
        case (cs_n)
            3'b110:  mem_rdata = dev0[mem_addr];
            3'b101:  mem_rdata = (mem_addr < 11'd512) ? dev1[mem_addr[8:0]] : 8'h00;
            3'b011:  mem_rdata = dev2[mem_addr];
            default: mem_rdata = 8'h5A;
        endcase
    end

    function automatic int region_of(input logic [15:0] a);
        case (a[15:11])
            5'b01010: return 0;
            5'b01011: return 1;
            5'b01101: return 2;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [7:0] ref_read(input logic [15:0] a);
        case (region_of(a))
            0:       return ref0[a[10:0]];
            1:       return ref1[a[8:0]];
            2:       return ref2[a[10:0]];
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard
    logic [7:0] exp_q[$];
    logic [7:0] rd_cap;
    event rd_done;

    initial begin
        forever begin
            @(rd_done);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected read result", rd_cap, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_cap == e, "R9", "read data", rd_cap, e);
            end
        end
    end

    task automatic access(input logic [15:0] a, input bit is_read, input logic [7:0] wd);
        int rg;
        logic [2:0]  exp_cs;
        logic [10:0] exp_ma;
        rg = region_of(a);
        exp_cs = 3'b111;
        if (rg >= 0) exp_cs[rg] = 1'b0;
        exp_ma = (rg == 1) ? {2'b00, a[8:0]} : a[10:0];

        @(negedge clk);
        e_clk = 1'b0; as_stb = 1'b1; rw_n = is_read; addr_hi = a[15:8]; ad_in = a[7:0];
        @(negedge clk);
        as_stb = 1'b0;
        @(negedge clk);
        ad_in = is_read ? ~a[7:0] : wd;
        #1;
        chk(addr_full == a, "R1", "address held after strobe", addr_full, a);
        chk(cs_n == 3'b111 && we_n && oe_n && !bus_drv_en, "R4", "low-phase strobes",
            {cs_n, we_n, oe_n, bus_drv_en}, 6'b111110);
        @(negedge clk);
        e_clk = 1'b1;
        #1;
        chk(addr_full == a, "R2", "rebuilt address", addr_full, a);
        chk(cs_n == exp_cs, "R3", "chip select", cs_n, exp_cs);
        chk(mem_addr == exp_ma, "R5", "memory address", mem_addr, exp_ma);
        chk(we_n == is_read, "R6", "write enable", we_n, is_read);
        if (!is_read) chk(mem_wdata == wd, "R6", "write data", mem_wdata, wd);
        chk(oe_n == !is_read, "R7", "output enable", oe_n, !is_read);
        chk(bus_drv_en == (is_read && rg >= 0), "R8", "drive enable", bus_drv_en,
            (is_read && rg >= 0));
        if (is_read && rg < 0)
            chk(bus_rd_data == 8'hFF, "R8", "idle byte", bus_rd_data, 8'hFF);
        if (is_read) exp_q.push_back(ref_read(a));
        @(negedge clk);
        @(negedge clk);
        if (is_read) begin
            rd_cap = bus_rd_data;
            -> rd_done;
        end else begin
            case (rg)
                0: ref0[a[10:0]] = wd;
                1: ref1[a[8:0]]  = wd;
                2: ref2[a[10:0]] = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        e_clk = 1'b0;
        #1;
        chk(bus_drv_en == 1'b0 && cs_n == 3'b111, "R8", "driver released at E fall",
            {bus_drv_en, cs_n}, 4'b0111);
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            dev0[i] = 8'h00; dev2[i] = 8'h00; ref0[i] = 8'h00; ref2[i] = 8'h00;
        end
        for (int i = 0; i < 512; i++) begin
            dev1[i] = 8'h00; ref1[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(addr_full[7:0] == 8'h00, "R1", "reset low byte", addr_full[7:0], 0);
        chk(cs_n == 3'b111 && we_n && oe_n && !bus_drv_en, "R4", "reset strobes",
            {cs_n, we_n, oe_n, bus_drv_en}, 6'b111110);
        chk(bus_rd_data == 8'hFF, "R8", "reset idle byte", bus_rd_data, 8'hFF);
        rst_n = 1'b1;

        // Region boundaries
        access(16'h5000, 1'b0, 8'h11);
        access(16'h57FF, 1'b0, 8'h22);
        access(16'h5800, 1'b0, 8'h33);
        access(16'h5801, 1'b0, 8'h44);
        access(16'h6800, 1'b0, 8'h55);
        access(16'h6FFF, 1'b0, 8'h66);
        access(16'h7000, 1'b0, 8'h77);
        access(16'h67FF, 1'b0, 8'h88);
        access(16'h5000, 1'b1, 8'h00);
        access(16'h57FF, 1'b1, 8'h00);
        access(16'h6800, 1'b1, 8'h00);
        access(16'h6FFF, 1'b1, 8'h00);
        // Mirrored region: R5 aliases
        access(16'h5A01, 1'b1, 8'h00);
        access(16'h5C01, 1'b1, 8'h00);
        access(16'h5E01, 1'b1, 8'h00);
        access(16'h5C00, 1'b1, 8'h00);
        access(16'h5FFF, 1'b0, 8'h99);
        access(16'h59FF, 1'b1, 8'h00);
        access(16'h5801, 1'b1, 8'h00);
        // Outside every region: R9 idle value
        access(16'h7000, 1'b1, 8'h00);
        access(16'h67FF, 1'b1, 8'h00);
        access(16'hD000, 1'b1, 8'h00);
        access(16'h4800, 1'b1, 8'h00);
        // Sweep
        for (int i = 0; i < 48; i++) begin
            logic [15:0] a;
            a = 16'h4F00 + 16'((i * 16'h0137) % 16'h2300);
            access(a, 1'b0, 8'(i * 37 + 5));
        end
        for (int i = 0; i < 48; i++) begin
            logic [15:0] a;
            a = 16'h4F00 + 16'((i * 16'h0137 + 16'h0600) % 16'h2300);
            access(a, 1'b1, 8'h00);
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule